// File: doc/BRIEF.md
# Flash Row Erase/Program Sequencer

This block controls erase and program operations on one row of a small on-chip program flash. A processor talks to it over a simple register write port. The port holds four registers: control, upper page, in-page offset and unlock key. The block also contains the row write latches and a timed behavioural model of the flash array. A read port lets the array contents be inspected.

To start an operation, software writes two key values to the key register in order. It then writes the control register with the start bit set, the write-enable bit set and a valid operation code. An accepted start raises `stall`, which holds the processor for a parameterised number of cycles. When the time is up, the row is erased or programmed, and the start bit clears itself. A start that fails any condition does nothing except set an error bit.

The latch loading port is a valid/ready stream. A word moves only in a cycle where `lat_valid` and `lat_ready` are both high. `lat_ready` drops for the whole time `stall` is high, so the sender must hold its word until the operation finishes. The read and register ports are plain control pins.

Top module: `flash_row_seq`

## Requirements
- R1: After reset, `stall` is low, `lat_ready` is high, the control register reads 0x0000, every array word reads all ones and every write latch holds all ones.
- R2: A key-register write of 0x0055 moves the unlock tracker to its first step from any state. A write of 0x00AA arms it only when it is in the first step. Any other key write returns it to the idle state. A start is accepted only when the tracker is armed.
- R3: Every control write with bit 15 set uses up the unlock, whether the start is accepted or rejected.
- R4: A start needs control bit 14 (write enable) in the same write. A rejected start sets control bit 13 (error) and leaves the array unchanged. An accepted start clears bit 13.
- R5: Control bits 6:0 select the operation: 0x41 is row erase and 0x01 is row program. Any other code rejects the start. The control word 0xC041 therefore starts a row erase.
- R6: The word address is {page, offset}, and the row is the address with its low 5 bits dropped. An address at or beyond the end of the array rejects the start.
- R7: After an accepted start, `stall` goes high in the next cycle and stays high for exactly OP_CYCLES cycles. Control bit 15 reads 1 during that time and 0 afterwards, with no software write needed to clear it.
- R8: An erase sets all 32 words of the addressed row to all ones and leaves every other row unchanged.
- R9: A program sets each word i of the addressed row to the old word AND latch i.
- R10: A latch word at index `lat_idx` (5 bits) is stored when `lat_valid` and `lat_ready` are both high. `lat_ready` is low whenever `stall` is high.
- R11: While `stall` is high, every register write is ignored, including key writes.
- R12: `rd_data` shows the array word at `rd_addr` in the same cycle, and it reflects a completed operation from the cycle after `stall` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 page, 2 offset, 3 key |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`; the key register reads zero |
| lat_valid | input | 1 | Latch word offered |
| lat_ready | output | 1 | Latch word can be taken |
| lat_idx | input | 5 | Latch index within the row |
| lat_data | input | 24 | Latch word |
| rd_addr | input | 8 | Array word address to read |
| rd_data | output | 24 | Array word at `rd_addr` |
| stall | output | 1 | High while an operation runs |

## Verification
The bench probes the unlock tracker with keys in reverse order, with a stray value between the two keys, and with a repeated first key. A tracker that ignored order or failed to reset would accept a start that should be rejected. It then uses one unlock on a start that lacks write enable and tries to start again. A design that kept the unlock alive would run the second start. During a busy period it writes a new offset, the full key pair and a latch word. A block that failed to gate these would move the row, arm itself, or corrupt the next program. Programming a row twice with different latch contents catches a model that overwrites words instead of ANDing them. Erasing one row while a neighbour is watched catches a wrong row decode.

// File: rtl/flash_row_seq_pkg.sv
package flash_row_seq_pkg;
  localparam logic [1:0] FRS_A_CTRL = 2'd0;
  localparam logic [1:0] FRS_A_PAGE = 2'd1;
  localparam logic [1:0] FRS_A_OFFS = 2'd2;
  localparam logic [1:0] FRS_A_KEY  = 2'd3;

  localparam logic [15:0] FRS_KEY_FIRST  = 16'h0055;
  localparam logic [15:0] FRS_KEY_SECOND = 16'h00AA;

  localparam int FRS_BIT_GO   = 15;
  localparam int FRS_BIT_WREN = 14;
  localparam int FRS_BIT_ERR  = 13;

  localparam logic [6:0] FRS_OP_ERASE = 7'h41;
  localparam logic [6:0] FRS_OP_PROG  = 7'h01;

  typedef enum logic [1:0] {
    UNL_IDLE  = 2'd0,
    UNL_HALF  = 2'd1,
    UNL_ARMED = 2'd2
  } unlock_state_e;
endpackage

// File: rtl/flash_row_unlock.sv
module flash_row_unlock
  import flash_row_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [15:0] key_data,
  input  logic        consume,
  output logic        armed
);
  unlock_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UNL_IDLE;
    end else if (consume) begin
      state_q <= UNL_IDLE;
    end else if (key_we) begin
      if (key_data == FRS_KEY_FIRST)
        state_q <= UNL_HALF;
      else if (key_data == FRS_KEY_SECOND && state_q == UNL_HALF)
        state_q <= UNL_ARMED;
      else
        state_q <= UNL_IDLE;
    end
  end

  assign armed = (state_q == UNL_ARMED);
endmodule

// File: rtl/flash_row_latch.sv
module flash_row_latch #(
  parameter int ROW_WORDS = 32,
  parameter int WORD_W    = 24,
  localparam int IDX_W    = $clog2(ROW_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        busy,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [IDX_W-1:0]            in_idx,
  input  logic [WORD_W-1:0]           in_data,
  output logic [ROW_WORDS*WORD_W-1:0] lat_bus
);
  assign in_ready = !busy;

  for (genvar g = 0; g < ROW_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '1;
      else if (in_valid && in_ready && in_idx == IDX_W'(g))
        word_q <= in_data;
    end
    assign lat_bus[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/flash_row_array.sv
module flash_row_array #(
  parameter int ROWS      = 8,
  parameter int ROW_WORDS = 32,
  parameter int WORD_W    = 24,
  parameter int OP_CYCLES = 50,
  localparam int IDX_W    = $clog2(ROW_WORDS),
  localparam int RIDX_W   = $clog2(ROWS),
  localparam int DEPTH    = ROWS * ROW_WORDS,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(OP_CYCLES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        erase_sel,
  input  logic [RIDX_W-1:0]           row,
  input  logic [ROW_WORDS*WORD_W-1:0] lat_bus,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [WORD_W-1:0]           rd_data,
  output logic                        busy,
  output logic                        done
);
  logic [CNT_W-1:0]  cnt_q;
  logic              erase_q;
  logic [RIDX_W-1:0] row_q;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      erase_q <= 1'b0;
      row_q   <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      cnt_q   <= CNT_W'(OP_CYCLES - 1);
      erase_q <= erase_sel;
      row_q   <= row;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '1;
    end else if (done) begin
      for (int i = 0; i < ROW_WORDS; i++) begin
        if (erase_q)
          mem[{row_q, IDX_W'(i)}] <= '1;
        else
          mem[{row_q, IDX_W'(i)}] <= mem[{row_q, IDX_W'(i)}] & lat_bus[i*WORD_W +: WORD_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_row_seq.sv
module flash_row_seq
  import flash_row_seq_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int ROW_WORDS = 32,
  parameter int WORD_W    = 24,
  parameter int PAGE_W    = 8,
  parameter int OP_CYCLES = 50,
  localparam int IDX_W    = $clog2(ROW_WORDS),
  localparam int RIDX_W   = $clog2(ROWS),
  localparam int DEPTH    = ROWS * ROW_WORDS,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int FULL_W   = PAGE_W + 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              lat_valid,
  output logic              lat_ready,
  input  logic [IDX_W-1:0]  lat_idx,
  input  logic [WORD_W-1:0] lat_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              stall
);
  logic              go_q, wren_q, err_q;
  logic [6:0]        op_q;
  logic [PAGE_W-1:0] page_q;
  logic [15:0]       offset_q;
  logic              armed, done;
  logic [ROW_WORDS*WORD_W-1:0] lat_bus;

  logic wr_ok, ctrl_we, key_we, try_go, op_ok, in_range, accept, is_erase;
  logic [FULL_W-1:0] full_addr;

  assign wr_ok     = reg_we && !stall;
  assign ctrl_we   = wr_ok && reg_addr == FRS_A_CTRL;
  assign key_we    = wr_ok && reg_addr == FRS_A_KEY;
  assign try_go    = ctrl_we && reg_wdata[FRS_BIT_GO];
  assign is_erase  = reg_wdata[6:0] == FRS_OP_ERASE;
  assign op_ok     = is_erase || reg_wdata[6:0] == FRS_OP_PROG;
  assign full_addr = {page_q, offset_q};
  assign in_range  = full_addr < FULL_W'(DEPTH);
  assign accept    = try_go && armed && reg_wdata[FRS_BIT_WREN] && op_ok && in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q     <= 1'b0;
      wren_q   <= 1'b0;
      err_q    <= 1'b0;
      op_q     <= '0;
      page_q   <= '0;
      offset_q <= '0;
    end else begin
      if (done) go_q <= 1'b0;
      if (ctrl_we) begin
        wren_q <= reg_wdata[FRS_BIT_WREN];
        op_q   <= reg_wdata[6:0];
        if (try_go) begin
          err_q <= !accept;
          go_q  <= accept;
        end
      end
      if (wr_ok && reg_addr == FRS_A_PAGE) page_q   <= reg_wdata[PAGE_W-1:0];
      if (wr_ok && reg_addr == FRS_A_OFFS) offset_q <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      FRS_A_CTRL: reg_rdata = {go_q, wren_q, err_q, 6'b0, op_q};
      FRS_A_PAGE: reg_rdata = 16'(page_q);
      FRS_A_OFFS: reg_rdata = offset_q;
      default:    reg_rdata = '0;
    endcase
  end

  flash_row_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (key_we),
    .key_data (reg_wdata),
    .consume  (try_go),
    .armed    (armed)
  );

  flash_row_latch #(.ROW_WORDS(ROW_WORDS), .WORD_W(WORD_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (stall),
    .in_valid (lat_valid),
    .in_ready (lat_ready),
    .in_idx   (lat_idx),
    .in_data  (lat_data),
    .lat_bus  (lat_bus)
  );

  flash_row_array #(
    .ROWS(ROWS), .ROW_WORDS(ROW_WORDS), .WORD_W(WORD_W), .OP_CYCLES(OP_CYCLES)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .erase_sel (is_erase),
    .row       (full_addr[ADDR_W-1:IDX_W]),
    .lat_bus   (lat_bus),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .busy      (stall),
    .done      (done)
  );
endmodule

// File: rtl/flash_row_seq_chk.sv
module flash_row_seq_chk #(
  parameter int OP_CYCLES = 50
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic        go,
  input logic        armed,
  input logic        wren,
  input logic        lat_ready,
  input logic [15:0] offset
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= 0;
    else if (stall) run_len <= run_len + 1;
    else            run_len <= 0;
  end

  // R7
  go_tracks_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) go == stall);
  // R7
  stall_length_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(stall) |-> run_len == OP_CYCLES);
  // R7
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) stall |-> run_len < OP_CYCLES);
  // R2
  start_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(stall) |-> $past(armed));
  // R3
  unlock_spent_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(stall) |-> !armed);
  // R4
  start_needs_wren_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(stall) |-> wren);
  // R10
  no_latch_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) stall |-> !lat_ready);
  // R11
  offset_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) (stall && $past(stall)) |-> $stable(offset));
endmodule

bind flash_row_seq flash_row_seq_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .go        (go_q),
  .armed     (armed),
  .wren      (wren_q),
  .lat_ready (lat_ready),
  .offset    (offset_q)
);

// File: tb/flash_row_seq_bench.sv
module flash_row_seq_bench;
  localparam int OPC   = 50;
  localparam int RW    = 32;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        lat_valid, lat_ready;
  logic [4:0]  lat_idx;
  logic [23:0] lat_data;
  logic [7:0]  rd_addr;
  logic [23:0] rd_data;
  logic        stall;

  always #5 clk = ~clk;

  flash_row_seq u_flash_row_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lat_valid(lat_valid),
    .lat_ready(lat_ready), .lat_idx(lat_idx), .lat_data(lat_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .stall(stall)
  );

  int vectors = 0, miscompares = 0;

  typedef struct {
    int          addr;
    logic [23:0] exp;
    string       tag;
  } item_t;

  item_t       sq[$];
  bit          mon_act = 1'b0;
  logic [23:0] ref_mem [DEPTH];
  logic [23:0] ref_lat [RW];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected words and compares the read port (R12)
  initial begin
    rd_addr = '0;
    forever begin
      item_t it;
      wait (sq.size() > 0);
      mon_act = 1'b1;
      it = sq.pop_front();
      @(negedge clk);
      rd_addr = 8'(it.addr);
      #1;
      check(rd_data === it.exp, it.tag, 32'(rd_data), 32'(it.exp));
      mon_act = 1'b0;
    end
  end

  task automatic check_row(input int row, input string tag);
    for (int i = 0; i < RW; i++) begin
      item_t it;
      it.addr = row * RW + i;
      it.exp  = ref_mem[row * RW + i];
      it.tag  = tag;
      sq.push_back(it);
    end
    wait (sq.size() == 0 && !mon_act);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic unlock();
    wr(2'd3, 16'h0055);
    wr(2'd3, 16'h00AA);
  endtask

  task automatic load_latches(input int sel);
    for (int i = 0; i < RW; i++) begin
      logic [23:0] d;
      d = (sel == 0) ? 24'((i * 24'h0B1357) ^ 24'hC0FFEE) : 24'((i * 24'h123457) ^ 24'h3F3F3F);
      @(negedge clk);
      lat_valid = 1'b1; lat_idx = 5'(i); lat_data = d;
      ref_lat[i] = d;
      @(negedge clk);
      lat_valid = 1'b0;
    end
  endtask

  task automatic model_op(input logic [15:0] ctrl, input int row);
    for (int i = 0; i < RW; i++) begin
      if (ctrl[6:0] == 7'h41) ref_mem[row * RW + i] = '1;
      else                    ref_mem[row * RW + i] = ref_mem[row * RW + i] & ref_lat[i];
    end
  endtask

  task automatic launch(input logic [15:0] ctrl, input bit ok, input int row, input string tag);
    int n;
    logic [15:0] v;
    n = 0;
    wr(2'd0, ctrl);
    if (ok) begin
      check(stall === 1'b1, {tag, " stall rises"}, 32'(stall), 1);
      rd(2'd0, v);
      check(v[15] === 1'b1, {tag, " R7 start bit while busy"}, 32'(v), 32'(ctrl));
      while (stall === 1'b1 && n < 1000) begin
        n++;
        @(negedge clk);
      end
      check(n == OPC, {tag, " R7 stall length"}, 32'(n), 32'(OPC));
      model_op(ctrl, row);
      rd(2'd0, v);
      check(v[15] === 1'b0 && v[13] === 1'b0, {tag, " R7 R4 start cleared, error clear"}, 32'(v), 32'(ctrl & 16'h7FFF));
    end else begin
      check(stall === 1'b0, {tag, " no stall"}, 32'(stall), 0);
      rd(2'd0, v);
      check(v[15] === 1'b0 && v[13] === 1'b1, {tag, " R4 error bit set"}, 32'(v), 32'((ctrl & 16'h5FFF) | 16'h2000));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '1;
    for (int i = 0; i < RW; i++) ref_lat[i] = '1;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    lat_valid = 1'b0; lat_idx = '0; lat_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(stall === 1'b0, "R1 stall low", 32'(stall), 0);
    check(lat_ready === 1'b1, "R1 latch ready", 32'(lat_ready), 1);
    rd(2'd0, v);
    check(v === 16'h0000, "R1 control reads zero", 32'(v), 0);
    check_row(0, "R1 array erased");

    // R1 latches hold ones: programming row 1 with untouched latches keeps ones
    wr(2'd2, 16'd32);
    unlock();
    launch(16'hC001, 1'b1, 1, "R1 R9 program with reset latches");
    check_row(1, "R1 latch reset value");

    // R9 program row 2 from erased state
    load_latches(0);
    wr(2'd2, 16'd64);
    unlock();
    launch(16'hC001, 1'b1, 2, "R9 first program");
    check_row(2, "R9 R12 row 2 programmed");
    check_row(3, "R8 neighbour row untouched");

    // R9 second program ANDs
    load_latches(1);
    unlock();
    launch(16'hC001, 1'b1, 2, "R9 second program");
    check_row(2, "R9 AND of old and latch");

    // R8 R5 erase with 0xC041
    unlock();
    launch(16'hC041, 1'b1, 2, "R5 R8 erase");
    check_row(2, "R8 row erased");
    check_row(1, "R8 other row unchanged");

    // R2 no unlock
    launch(16'hC001, 1'b0, 2, "R2 no unlock");
    // R2 reverse order
    wr(2'd3, 16'h00AA); wr(2'd3, 16'h0055);
    launch(16'hC001, 1'b0, 2, "R2 reversed keys");
    // R2 stray write between keys
    wr(2'd3, 16'h0055); wr(2'd3, 16'h0012); wr(2'd3, 16'h00AA);
    launch(16'hC001, 1'b0, 2, "R2 broken sequence");
    check_row(2, "R2 rejected starts leave row");
    // R2 repeated first key still arms
    wr(2'd3, 16'h0055); wr(2'd3, 16'h0055); wr(2'd3, 16'h00AA);
    launch(16'hC001, 1'b1, 2, "R2 repeated first key");
    check_row(2, "R2 R9 row 2 programmed");

    // R4 then R3 unlock spent
    unlock();
    launch(16'h8001, 1'b0, 2, "R4 write enable clear");
    launch(16'hC001, 1'b0, 2, "R3 unlock used up");

    // R5 bad op code
    unlock();
    launch(16'hC002, 1'b0, 2, "R5 bad op code");

    // R6 address range
    wr(2'd2, 16'd256);
    unlock();
    launch(16'hC041, 1'b0, 0, "R6 offset past end");
    wr(2'd1, 16'h0001); wr(2'd2, 16'h0000);
    unlock();
    launch(16'hC041, 1'b0, 0, "R6 page past end");
    check_row(0, "R6 rejected leaves row 0");
    wr(2'd1, 16'h0000); wr(2'd2, 16'd229);
    unlock();
    launch(16'hC001, 1'b1, 7, "R6 mid-row address");
    check_row(7, "R6 row 7 programmed");

    // R10 R11 writes and latch offers during busy
    unlock();
    wr(2'd0, 16'hC041);
    check(stall === 1'b1, "R11 erase busy", 32'(stall), 1);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0055);
    wr(2'd3, 16'h00AA);
    @(negedge clk);
    lat_valid = 1'b1; lat_idx = 5'd0; lat_data = 24'h000000;
    #1;
    check(lat_ready === 1'b0, "R10 ready low while busy", 32'(lat_ready), 0);
    @(negedge clk);
    lat_valid = 1'b0;
    wait (stall === 1'b0);
    @(negedge clk);
    model_op(16'hC041, 7);
    check_row(7, "R8 row 7 erased");
    rd(2'd2, v);
    check(v === 16'd229, "R11 offset unchanged", 32'(v), 229);
    launch(16'hC001, 1'b0, 7, "R11 keys ignored while busy");
    unlock();
    launch(16'hC001, 1'b1, 7, "R10 latch kept after busy offer");
    check_row(7, "R10 latch word 0 intact");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule